// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

This block is a synthesizable behavioural model of a synchronous static RAM that accepts a new command on every enabled rising clock edge. Reads and writes can sit on adjacent cycles with no idle cycle between them. A read is flow-through: the word for an address registered on one edge is presented during the cycle that follows that edge. A write is late: the address and byte mask are taken on one edge, and the write data is taken on the next enabled edge. Both transfers fit in the same cycle, so the shared array stays fully busy.

Each access can open a four-beat burst. The two lowest address bits seed a burst counter. Holding the advance/load input high then steps through the burst in linear or interleaved order, in the direction chosen when the burst began. A clock-enable input freezes the whole block for as long as it stays high.

A data-out valid flag takes the place of tri-state pins. It is high only while a read access is current and the asynchronous output enable is asserted. The array is a small register file with one storage element per byte lane.

Top module: `ntsram_core`

## Requirements
- R1: While `rst` is high, the block returns to the idle (deselected) state. After reset, `rvalid` stays low until a read is started.
- R2: A new access starts on a rising edge only when all of the following hold: `cke_n`=0, `adv_ld`=0, `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. `we_n`=1 selects a read and `we_n`=0 selects a write.
- R3: An edge with `cke_n`=0, `adv_ld`=0 and any select inactive is a deselect, and `rvalid` goes low. Later edges with `adv_ld`=1 keep the block deselected, and the selects are ignored on those edges.
- R4: After an edge that starts or continues a read, during the following cycle `rdata` holds the stored word at the current burst address, and `rvalid` is 1 whenever `oe_n`=0.
- R5: `oe_n` acts without a clock. While `oe_n`=1, `rvalid`=0 and `rdata`=0. A read taken with `oe_n` high still consumes its address and advances the burst. Whenever `rvalid`=0, `rdata` is 0.
- R6: For a write access registered on one edge, `wdata` is captured on the next edge that has `cke_n`=0. No write access ever sets `rvalid`.
- R7: `bw_n` is active low and is sampled on the same edge as the write address. Bit i of `bw_n` enables `rdata`/`wdata` bits [8i+7:8i]. Lanes whose enable is 1 keep their old contents.
- R8: A write beat with `bw_n` all ones is an abort: no lane changes, but the burst position still advances.
- R9: An edge with `cke_n`=0 and `adv_ld`=1 during an active access moves to the next burst beat. It keeps the direction and the upper address bits [ADDR_W-1:2] of the starting address. After four beats the burst wraps back to the starting address.
- R10: With `ilv_burst`=0, the low two address bits of beat n are (start + n) mod 4. With `ilv_burst`=1, they are start XOR n.
- R11: An edge with `cke_n`=1 changes nothing: all other synchronous inputs are ignored, read output stays valid, and a pending write waits for the next edge with `cke_n`=0.
- R12: A read of the address whose late-write data is captured on the same edge returns the newly written bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ilv_burst | input | 1 | Burst order: 0 linear, 1 interleaved (held static) |
| addr | input | ADDR_W | Word address; bits [1:0] seed the burst counter |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 loads a new command, 1 continues the burst |
| we_n | input | 1 | 0 write, 1 read, sampled at load |
| bw_n | input | NBYTES | Per-lane write enables, active low |
| cke_n | input | 1 | Clock enable, active low; high stalls the block |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | NBYTES*BYTE_W | Late-write data |
| rdata | output | NBYTES*BYTE_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data driven (replaces the tri-state pins) |

## Verification
A wrong burst counter or a lost burst base shows up one cycle after the edge: `rdata` then carries a word from another address. A lost direction flag shows up as `rvalid` rising during a write burst, or falling in the middle of a read. A write committed to the wrong lane or address, or on a stalled edge, stays hidden until that location is read back, so the stream reads every location often. A stall that fails to freeze state shows up at once as a changed `rdata` or `rvalid` while `cke_n` is high.

// File: rtl/ntsram_pkg.sv
package ntsram_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low address bits of a burst beat: counter added (linear) or xored (interleaved).
  function automatic logic [BURST_W-1:0] beat_low(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] beat,
    input logic               ilv
  );
    logic [BURST_W-1:0] r;
    if (ilv) r = start ^ beat;
    else     r = start + beat;
    return r;
  endfunction

endpackage

// File: rtl/ntsram_burst_addr.sv
module ntsram_burst_addr
  import ntsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [BURST_W-1:0] beat,
  input  logic               ilv,
  output logic [ADDR_W-1:0]  word_addr
);

  assign word_addr = {base[ADDR_W-1:BURST_W], beat_low(base[BURST_W-1:0], beat, ilv)};

endmodule

// File: rtl/ntsram_ctrl.sv
module ntsram_ctrl
  import ntsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cke_n,
  input  logic               adv_ld,
  input  logic               selected,
  input  logic               we_n,
  input  logic [NBYTES-1:0]  bw_n,
  input  logic [ADDR_W-1:0]  addr,
  output op_e                op,
  output logic [ADDR_W-1:0]  base,
  output logic [BURST_W-1:0] beat,
  output logic [NBYTES-1:0]  lane_en
);

  op_e                op_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] beat_q;
  logic [NBYTES-1:0]  lane_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      beat_q <= '0;
      lane_q <= '0;
    end else if (!cke_n) begin
      if (!adv_ld) begin
        if (selected) begin
          op_q   <= we_n ? OP_READ : OP_WRITE;
          base_q <= addr;
          beat_q <= '0;
        end else begin
          op_q   <= OP_IDLE;
        end
      end else if (op_q != OP_IDLE) begin
        beat_q <= beat_q + BURST_W'(1);
      end
      lane_q <= ~bw_n;
    end
  end

  assign op      = op_q;
  assign base    = base_q;
  assign beat    = beat_q;
  assign lane_en = lane_q;

endmodule

// File: rtl/ntsram_array.sv
module ntsram_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     commit,
  input  logic [ADDR_W-1:0]        word_addr,
  input  logic [NBYTES-1:0]        lane_en,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  output logic [NBYTES*BYTE_W-1:0] rword
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (commit && lane_en[g]) store[word_addr] <= wdata[g*BYTE_W +: BYTE_W];
    end

    assign rword[g*BYTE_W +: BYTE_W] = store[word_addr];
  end

endmodule

// File: rtl/ntsram_core.sv
module ntsram_core
  import ntsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ilv_burst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     cs_a_n,
  input  logic                     cs_b,
  input  logic                     cs_c_n,
  input  logic                     adv_ld,
  input  logic                     we_n,
  input  logic [NBYTES-1:0]        bw_n,
  input  logic                     cke_n,
  input  logic                     oe_n,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  output logic [NBYTES*BYTE_W-1:0] rdata,
  output logic                     rvalid
);

  localparam int DW = NBYTES * BYTE_W;

  op_e                op;
  logic [ADDR_W-1:0]  base;
  logic [BURST_W-1:0] beat;
  logic [NBYTES-1:0]  lane_en;
  logic [ADDR_W-1:0]  word_addr;
  logic [DW-1:0]      rword;
  logic               selected;
  logic               commit;

  assign selected = !cs_a_n && cs_b && !cs_c_n;

  ntsram_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) ctrl_i (
    .clk(clk), .rst(rst), .cke_n(cke_n), .adv_ld(adv_ld), .selected(selected),
    .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .op(op), .base(base), .beat(beat), .lane_en(lane_en)
  );

  ntsram_burst_addr #(.ADDR_W(ADDR_W)) seq_i (
    .base(base), .beat(beat), .ilv(ilv_burst), .word_addr(word_addr)
  );

  // Late write: the beat registered last edge takes its data on this enabled edge.
  assign commit = !cke_n && (op == OP_WRITE);

  ntsram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) array_i (
    .clk(clk), .commit(commit), .word_addr(word_addr), .lane_en(lane_en),
    .wdata(wdata), .rword(rword)
  );

  assign rvalid = (op == OP_READ) && !oe_n;
  assign rdata  = rvalid ? rword : '0;

endmodule

// File: rtl/ntsram_core_chk.sv
module ntsram_core_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_a_n,
  input logic          cs_b,
  input logic          cs_c_n,
  input logic          adv_ld,
  input logic          we_n,
  input logic          cke_n,
  input logic          oe_n,
  input logic [DW-1:0] rdata,
  input logic          rvalid
);

  logic sel_ok;
  assign sel_ok = !cs_a_n && cs_b && !cs_c_n;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !rvalid);

  assert_desel_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !adv_ld && !sel_ok) |=> !rvalid);

  assert_read_drives_R4: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !adv_ld && sel_ok && we_n) |=> (oe_n || rvalid));

  assert_write_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !adv_ld && sel_ok && !we_n) |=> !rvalid);

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
    cke_n |=> ((oe_n != $past(oe_n)) || ($stable(rvalid) && $stable(rdata))));

endmodule

bind ntsram_core ntsram_core_chk #(.DW(NBYTES*BYTE_W)) chk_i (
  .clk(clk), .rst(rst), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
  .adv_ld(adv_ld), .we_n(we_n), .cke_n(cke_n), .oe_n(oe_n),
  .rdata(rdata), .rvalid(rvalid)
);

// File: tb/ntsram_core_tb.sv
module ntsram_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int NB    = 4;
  localparam int BW    = 8;
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ilv_burst = 1'b0;
  logic [AW-1:0] addr = '0;
  logic cs_a_n = 1'b1, cs_b = 1'b0, cs_c_n = 1'b1;
  logic adv_ld = 1'b1, we_n = 1'b1, cke_n = 1'b1, oe_n = 1'b1;
  logic [NB-1:0] bw_n = '1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid;

  always #(CLK_PERIOD/2) clk = ~clk;

  ntsram_core #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) dut_i (
    .clk(clk), .rst(rst), .ilv_burst(ilv_burst), .addr(addr),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n), .adv_ld(adv_ld),
    .we_n(we_n), .bw_n(bw_n), .cke_n(cke_n), .oe_n(oe_n),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  int total = 0;
  int bad = 0;

  // Reference state: 0 idle, 1 read, 2 write
  logic [DW-1:0] refmem [DEPTH];
  int            m_op = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic [NB-1:0] m_lanes = '0;

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo;
    lo = ilv_burst ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(input string tg);
    logic          ev;
    logic [DW-1:0] ed;
    ev = (m_op == 1) && !oe_n;
    ed = ev ? refmem[m_addr()] : '0;
    total++;
    if (rvalid !== ev) begin
      bad++;
      $display("FAIL %s rvalid actual=%0b expected=%0b", tg, rvalid, ev);
    end
    total++;
    if (rdata !== ed) begin
      bad++;
      $display("FAIL %s rdata actual=%h expected=%h", tg, rdata, ed);
    end
  endtask

  task automatic model_edge();
    if (!cke_n) begin
      if (m_op == 2) begin
        for (int i = 0; i < NB; i++)
          if (m_lanes[i]) refmem[m_addr()][i*BW +: BW] = wdata[i*BW +: BW];
      end
      if (!adv_ld) begin
        if (!cs_a_n && cs_b && !cs_c_n) begin
          m_op   = we_n ? 1 : 2;
          m_base = addr;
          m_beat = '0;
        end else begin
          m_op = 0;
        end
      end else if (m_op != 0) begin
        m_beat = m_beat + 2'd1;
      end
      m_lanes = ~bw_n;
    end
  endtask

  task automatic step(input bit s, input bit adv, input bit we, input logic [NB-1:0] bw,
                      input bit ck, input bit oe, input logic [AW-1:0] a, input string tg);
    @(negedge clk);
    if (s) begin
      cs_a_n = 1'b0; cs_b = 1'b1; cs_c_n = 1'b0;
    end else begin
      cs_a_n = 1'b0; cs_b = 1'b1; cs_c_n = 1'b0;
      case ($urandom % 3)
        0: cs_a_n = 1'b1;
        1: cs_b   = 1'b0;
        default: cs_c_n = 1'b1;
      endcase
    end
    adv_ld = adv; we_n = we; bw_n = bw; cke_n = ck; oe_n = oe; addr = a;
    wdata  = $urandom;
    #1 check(tg);
    @(posedge clk);
    model_edge();
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    total++;
    if (rvalid !== 1'b0) begin
      bad++;
      $display("FAIL R1 rvalid after reset actual=%0b expected=0", rvalid);
    end
    step(1, 1, 1, '1, 0, 0, '0, "R1");

    // Fill the array with linear write bursts (R6, R9)
    for (int k = 0; k < DEPTH/4; k++) begin
      step(1, 0, 0, '0, 0, 0, AW'(k*4), "R6");
      for (int b = 0; b < 3; b++) step(1, 1, 0, '0, 0, 0, '0, "R9");
    end
    step(0, 0, 1, '1, 0, 0, '0, "R3");

    // Linear read burst, start not aligned, with wrap
    step(1, 0, 1, '1, 0, 0, 6'd6, "R4");
    for (int b = 0; b < 4; b++) step(1, 1, 1, '1, 0, 0, '0, "R10");

    // Interleaved read burst
    ilv_burst = 1'b1;
    step(1, 0, 1, '1, 0, 0, 6'd9, "R10");
    for (int b = 0; b < 4; b++) step(1, 1, 1, '1, 0, 0, '0, "R10");
    ilv_burst = 1'b0;

    // Deselect, then continued deselect with selects active
    step(0, 0, 1, '1, 0, 0, 6'd3, "R3");
    step(1, 1, 1, '1, 0, 0, 6'd3, "R3");
    step(1, 1, 0, '0, 0, 0, 6'd3, "R3");

    // Start blocked by one inactive select
    step(0, 0, 1, '1, 0, 0, 6'd5, "R2");
    step(1, 1, 1, '1, 0, 0, 6'd5, "R2");

    // Dummy read then visible continuation
    step(1, 0, 1, '1, 0, 1, 6'd12, "R5");
    step(1, 1, 1, '1, 0, 0, '0, "R5");
    step(1, 1, 1, '1, 0, 1, '0, "R5");
    step(1, 1, 1, '1, 0, 0, '0, "R5");

    // Byte-lane write, read back straight after
    step(1, 0, 0, 4'b1010, 0, 0, 6'd20, "R7");
    step(1, 0, 1, '1, 0, 0, 6'd20, "R7");
    step(1, 1, 1, '1, 0, 0, '0, "R7");

    // Write abort on first beat, full write on second
    step(1, 0, 0, 4'hF, 0, 0, 6'd24, "R8");
    step(1, 1, 0, 4'h0, 0, 0, '0, "R8");
    step(1, 0, 1, '1, 0, 0, 6'd24, "R8");
    step(1, 1, 1, '1, 0, 0, '0, "R8");
    step(1, 1, 1, '1, 0, 0, '0, "R8");

    // Stall during read and between write address and data
    step(1, 0, 1, '1, 0, 0, 6'd30, "R11");
    for (int b = 0; b < 3; b++) step(b[0], 0, b[1], 4'h0, 1, 0, 6'd7, "R11");
    step(1, 1, 1, '1, 0, 0, '0, "R11");
    step(1, 0, 0, '0, 0, 0, 6'd33, "R11");
    step(0, 0, 1, 4'hF, 1, 0, 6'd7, "R11");
    step(1, 0, 1, 4'h5, 1, 0, 6'd2, "R11");
    step(1, 0, 1, '1, 0, 0, 6'd33, "R11");
    step(0, 0, 1, '1, 0, 0, '0, "R11");

    // Read of the address whose data lands on the same edge
    step(1, 0, 0, '0, 0, 0, 6'd40, "R12");
    step(1, 0, 1, '1, 0, 0, 6'd40, "R12");
    step(1, 1, 0, 4'b0110, 0, 0, '0, "R12");
    step(1, 0, 1, '1, 0, 0, 6'd41, "R12");
    step(0, 0, 1, '1, 0, 0, '0, "R12");

    // Mixed random stream
    for (int n = 0; n < 4000; n++) begin
      if (n == 2000) ilv_burst = 1'b1;
      step(($urandom % 5) != 0, $urandom % 2, $urandom % 2, NB'($urandom),
           ($urandom % 6) == 0, ($urandom % 4) == 0, AW'($urandom), "R2");
    end

    finish_run();
  end

endmodule